// File: doc/BRIEF.md
# I/O Wait-State Generator for a Fast Z80 Bus

This block lets a Z80 clocked well above the usual bus rate work with slower I/O peripherals. It watches the CPU control strobes on the processor clock and, for each I/O read, I/O write or interrupt-acknowledge machine cycle, holds the active-low wait line down for a programmable number of T-states. Memory cycles are not touched, so memory accesses keep running at full speed.

The generator updates its state on the falling clock edge, which gives the CPU a settled wait level when it samples. By default it runs in hold-first form. As soon as a qualifying I/O strobe appears, wait is driven low without waiting for a register, and it is let go only once the count has run out. If the logic is late, the result is an extra wait state rather than a missing one. The generator's request is combined with the open-drain bus wait line, so either source can stall the CPU.

Top module: `z80_io_stretch`

## Requirements
- R1: While reset is low, `wait_req_n` and `cpu_wait_n` are high, whatever the strobes and count are. Asserting reset in the middle of a stretch releases wait at once.
- R2: An I/O read (`iorq_n` and `rd_n` low, `mreq_n` high) lasts 4 + N T-states, where N is `wait_cnt`.
- R3: An I/O write (`iorq_n` and `wr_n` low, `mreq_n` high) lasts 4 + N T-states.
- R4: An interrupt acknowledge (`m1_n` low, then `iorq_n` low, with `rd_n` and `wr_n` high) lasts 5 + N T-states.
- R5: With `wait_cnt` = 0, `wait_req_n` never goes low.
- R6: A memory cycle (`mreq_n` low, `iorq_n` high) sees `wait_req_n` and `cpu_wait_n` high throughout.
- R7: Each `iorq_n` low period gets exactly one stretch of N falling-edge samples. If the external wait keeps the cycle going longer, the generator does not start a second stretch until `iorq_n` has returned high.
- R8: `cpu_wait_n` is low whenever `ext_wait_n` or `wait_req_n` is low. The cycle is extended by the longer of the two.
- R9: In hold-first mode with N > 0, `wait_req_n` falls in the same half-cycle as the qualifying `iorq_n` fall, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq_n | input | 1 | I/O request strobe |
| mreq_n | input | 1 | Memory request strobe |
| m1_n | input | 1 | Opcode fetch / acknowledge marker |
| rd_n | input | 1 | Read strobe |
| wr_n | input | 1 | Write strobe |
| wait_cnt | input | CNT_W | Wait states per I/O or acknowledge cycle |
| ext_wait_n | input | 1 | Wait line from the rest of the bus |
| wait_req_n | output | 1 | Wait request from this generator |
| cpu_wait_n | output | 1 | Combined wait to the CPU |

## Verification
The checker verifies on every cycle that reset releases wait and clears the counter, and that the request stays high when the count is zero or `iorq_n` is idle. It also checks that no reload occurs after a stretch has finished inside one I/O period, that either wait source pulls the CPU line low, and that the hold-first request falls together with the strobe. Only the bench's bus scenarios can show the T-state length of whole read, write and acknowledge cycles for every count. The same applies to the interaction of a long external wait with a short internal one, and to the full-speed memory cycle.

// File: rtl/z80_io_stretch.sv
module z80_io_stretch #(
  parameter int CNT_W      = 3,
  parameter bit HOLD_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iorq_n,
  input  logic             mreq_n,
  input  logic             m1_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [CNT_W-1:0] wait_cnt,
  input  logic             ext_wait_n,
  output logic             wait_req_n,
  output logic             cpu_wait_n
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             req;
  logic             busy;
  logic             hold;
  logic [CNT_W-1:0] load_val;

  assign req  = ~iorq_n & mreq_n & (~rd_n | ~wr_n | ~m1_n);
  assign busy = |cnt;

  generate
    if (HOLD_FIRST) begin : g_hold
      assign hold     = rst_n & armed & req & (|wait_cnt);
      assign load_val = (|wait_cnt) ? wait_cnt - ONE : '0;
    end else begin : g_late
      assign hold     = 1'b0;
      assign load_val = wait_cnt;
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (iorq_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed && req) begin
      cnt   <= load_val;
      armed <= 1'b0;
    end else if (busy) begin
      cnt   <= cnt - ONE;
    end
  end

  assign wait_req_n = ~(hold | busy);
  assign cpu_wait_n = wait_req_n & ext_wait_n;

endmodule

// File: rtl/z80_io_stretch_chk.sv
module z80_io_stretch_chk #(
  parameter int CNT_W      = 3,
  parameter bit HOLD_FIRST = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iorq_n,
  input logic             mreq_n,
  input logic             m1_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic [CNT_W-1:0] wait_cnt,
  input logic             ext_wait_n,
  input logic             wait_req_n,
  input logic             cpu_wait_n,
  input logic [CNT_W-1:0] cnt,
  input logic             armed
);

  a_r1_reset_release: assert property (@(posedge clk)
    !rst_n |-> (wait_req_n && cpu_wait_n == ext_wait_n && cnt == '0));

  a_r5_zero_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt == '0 && cnt == '0) |-> wait_req_n);

  a_r6_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n && $past(iorq_n)) |-> wait_req_n);

  a_r7_single_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !armed && cnt == '0) |=> cnt == '0);

  a_r8_ext_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wait_n |-> !cpu_wait_n);

  a_r8_gen_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_req_n |-> !cpu_wait_n);

  generate
    if (HOLD_FIRST) begin : g_first
      a_r9_hold_first: assert property (@(negedge clk) disable iff (!rst_n)
        ($fell(iorq_n) && mreq_n && !(rd_n && wr_n && m1_n) && wait_cnt != '0)
        |-> !wait_req_n);
    end
  endgenerate

endmodule

bind z80_io_stretch z80_io_stretch_chk #(.CNT_W(CNT_W), .HOLD_FIRST(HOLD_FIRST)) u_chk (
  .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .m1_n(m1_n),
  .rd_n(rd_n), .wr_n(wr_n), .wait_cnt(wait_cnt), .ext_wait_n(ext_wait_n),
  .wait_req_n(wait_req_n), .cpu_wait_n(cpu_wait_n), .cnt(cnt), .armed(armed)
);

// File: tb/sim_z80_io_stretch.sv
`timescale 1ns/100ps
module sim_z80_io_stretch;

  logic       clk = 1'b0;
  logic       rst_n, iorq_n, mreq_n, m1_n, rd_n, wr_n, ext_wait_n;
  logic [2:0] wait_cnt;
  logic       wait_req_n, cpu_wait_n;
  logic       busy = 1'b0;

  typedef struct { int len; string tag; } exp_t;
  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;

  always #2 clk = ~clk;

  z80_io_stretch u0 (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .wait_cnt(wait_cnt), .ext_wait_n(ext_wait_n),
    .wait_req_n(wait_req_n), .cpu_wait_n(cpu_wait_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: counts T-states of each bus cycle and compares with the queue
  initial begin
    forever begin
      int len;
      exp_t e;
      @(posedge busy);
      len = 0;
      forever begin
        @(negedge clk);
        if (!busy) break;
        len++;
      end
      if (exp_q.size() == 0) chk(1'b0, "queue", len, -1);
      else begin
        e = exp_q.pop_front();
        chk(len == e.len, e.tag, len, e.len);
      end
    end
  end

  // kind: 0 I/O read, 1 I/O write, 2 interrupt acknowledge
  task automatic bus_cycle(input int kind, input int n, input int ext_hold);
    string tag;
    int    extra = 0;
    int    gen_low = 0;
    int    longest;
    exp_t  e;
    tag = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
    longest = (n > ext_hold) ? n : ext_hold;
    wait_cnt = 3'(n);
    @(posedge clk); #1;
    busy = 1'b1;
    if (kind == 2) m1_n = 1'b0;
    e.len = ((kind == 2) ? 5 : 4) + longest;
    e.tag = (ext_hold > 0) ? "R8" : tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    if (kind == 2) begin @(posedge clk); #1; end
    iorq_n = 1'b0;
    if (kind == 0) rd_n = 1'b0;
    if (kind == 1) wr_n = 1'b0;
    if (ext_hold > 0) ext_wait_n = 1'b0;
    forever begin
      if (extra >= ext_hold) ext_wait_n = 1'b1;
      #0.5;
      if (extra == 0 && n > 0) chk(wait_req_n == 1'b0, "R9", int'(wait_req_n), 0);
      if (!wait_req_n) gen_low++;
      if (cpu_wait_n) break;
      extra++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    busy = 1'b0;
    chk(gen_low == n, (n == 0) ? "R5" : (ext_hold > n) ? "R7" : tag, gen_low, n);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iorq_n = 1'b0; mreq_n = 1'b1; m1_n = 1'b1;
    rd_n = 1'b0; wr_n = 1'b1; ext_wait_n = 1'b1; wait_cnt = 3'd5;
    repeat (3) @(posedge clk);
    #1.5;
    chk(wait_req_n && cpu_wait_n, "R1", int'(wait_req_n & cpu_wait_n), 1);
    iorq_n = 1'b1; rd_n = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int n = 0; n < 8; n++) begin
      bus_cycle(0, n, 0);
      bus_cycle(1, n, 0);
      bus_cycle(2, n, 0);
    end

    // external wait longer than the internal stretch (R7, R8)
    bus_cycle(0, 2, 5);
    bus_cycle(2, 1, 4);
    bus_cycle(1, 0, 3);
    // internal stretch longer than the external one (R8)
    bus_cycle(1, 6, 2);

    // memory cycle at full speed (R6)
    wait_cnt = 3'd7;
    @(posedge clk); #1;
    mreq_n = 1'b0; rd_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1.5;
      chk(wait_req_n && cpu_wait_n, "R6", int'(wait_req_n & cpu_wait_n), 1);
    end
    mreq_n = 1'b1; rd_n = 1'b1;

    // external wait alone while idle (R8)
    @(posedge clk); #1;
    ext_wait_n = 1'b0; #0.5;
    chk(!cpu_wait_n && wait_req_n, "R8", int'(cpu_wait_n), 0);
    ext_wait_n = 1'b1;

    // reset in the middle of a stretch (R1)
    @(posedge clk); #1;
    iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!wait_req_n, "R3", int'(wait_req_n), 0);
    rst_n = 1'b0; #0.5;
    chk(wait_req_n && cpu_wait_n, "R1", int'(wait_req_n & cpu_wait_n), 1);
    @(posedge clk); #1;
    iorq_n = 1'b1; wr_n = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "queue", exp_q.size(), 0);
    finish_run();
  end

endmodule